// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes that a display transmitter needs, together with the active pixel column and line indices, a one-clock frame-start marker and an interlace field flag. Software programs the geometry through a narrow write port. Each timing word carries the horizontal value in its low half and the vertical value in its high half. Every count is stored as its true value minus one. The back-porch field is measured from the start of sync, so it covers the sync pulse plus the real back porch.

Each axis is one enumerated state machine with the states IDLE, SYNC, PORCH, ACTIVE and FRONT. The transitions are:
- IDLE to SYNC on the first enabled clock.
- SYNC to PORCH when the position reaches the sync field.
- SYNC straight to ACTIVE when the sync field equals the back-porch field, which gives a zero-length porch.
- PORCH to ACTIVE at the back-porch field.
- ACTIVE to FRONT at the end of the active region.
- FRONT back to SYNC on the last position of the line or frame.
- Any state back to IDLE when the enable is cleared.

The horizontal machine steps on every clock. The vertical machine steps once per line, on the clock where the horizontal machine leaves FRONT. Every value written is staged and copied into a working set only at a frame boundary, or at any clock while the generator is stopped. A running frame is therefore never altered partway through.

Top module: `vtg_top`

## Requirements
- R1: The write port stores a word when `cfg_we` is high, selected by `cfg_addr`. The addresses are: 0 control, 1 active size, 2 back porch measured from sync start, 3 front porch, 4 sync width, 5 polarity. Addresses 6 and 7 are ignored. In timing words, bits 15:0 hold the horizontal field and bits 31:16 hold the vertical field, each equal to the count minus one.
- R2: With horizontal fields sw, bp, act and fp, a line lasts bp+act+fp+3 clocks. Hsync is asserted for the first sw+1 clocks of the line. The active pixels start bp+1 clocks after line start. The rule bp >= sw applies, and bp = sw gives no porch clocks.
- R3: The vertical axis follows the same sequence counted in lines, with the vertical fields. It advances on the last clock of each line.
- R4: `de` is high exactly when both axes are inside their active regions.
- R5: Polarity word bit 0 controls hsync and bit 1 controls vsync. A set bit makes that sync active-high; a clear bit makes it active-low. The inactive level is the opposite.
- R6: Control bit 31 enables the generator. While it is clear, both axes stay in IDLE, the syncs are inactive, `de`, `frame_start`, `col`, `row` and `field` are 0, and the first enabled clock is idle. `frame_start` is first seen in the second clock after the edge that stores the enable.
- R7: `frame_start` is high for exactly the first clock of each frame.
- R8: `col` is the active pixel index while the horizontal axis is active, halved when control bit 0 (2x repetition) is set. `row` is the active line index while the vertical axis is active. Both are 0 elsewhere.
- R9: Timing, polarity, interlace and repetition writes take effect only at the boundary following the last clock of a frame, at the clock of the enable being seen, or at any clock while disabled.
- R10: When control bit 4 (interlace) is set, `field` toggles at each frame boundary. When it is clear, `field` returns to 0 at the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (3) | Register select |
| cfg_wdata | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync, programmable polarity |
| vsync_o | output | 1 | Vertical sync, programmable polarity |
| de_o | output | 1 | Data enable |
| col_o | output | 16 | Active pixel column index |
| row_o | output | 16 | Active line index |
| frame_start_o | output | 1 | First clock of frame |
| field_o | output | 1 | Interlace field flag |

## Verification
The assertions check on every cycle that:
- the working configuration never changes outside a load slot;
- the last clock of FRONT always returns the axis to SYNC at position zero;
- clearing the enable puts both machines in IDLE on the next clock;
- `frame_start` never lasts two clocks.

Only the bench's scenarios can show that whole lines and frames have the programmed lengths and ordering, that the syncs take the right polarity, and that the column index is halved under repetition. The same holds for reloading mid-frame, which must leave the current frame intact, and for the field flag alternating across frames.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    localparam int FIELD_W = 16;

    localparam int ADR_CTRL  = 0;
    localparam int ADR_ACT   = 1;
    localparam int ADR_BACK  = 2;
    localparam int ADR_FRONT = 3;
    localparam int ADR_SYNC  = 4;
    localparam int ADR_POL   = 5;

    localparam int BIT_EN    = 31;
    localparam int BIT_ILACE = 4;
    localparam int BIT_REP   = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_PORCH,
        ST_ACTIVE,
        ST_FRONT
    } axis_state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] act;
        logic [FIELD_W-1:0] bp;
        logic [FIELD_W-1:0] fp;
        logic [FIELD_W-1:0] sw;
    } axis_cfg_t;

    typedef struct packed {
        logic      interlace;
        logic      rep2x;
        logic [1:0] pol;
        axis_cfg_t h;
        axis_cfg_t v;
    } vtg_cfg_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              frame_end,
    input  logic              idle_load,
    output logic              en,
    output vtg_cfg_t          shadow
);
    logic        ilace_q, rep_q;
    logic [1:0]  pol_q;
    logic [31:0] act_q, bp_q, fp_q, sw_q;
    vtg_cfg_t    stage;
    logic        load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en      <= 1'b0;
            ilace_q <= 1'b0;
            rep_q   <= 1'b0;
            pol_q   <= '0;
            act_q   <= '0;
            bp_q    <= '0;
            fp_q    <= '0;
            sw_q    <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(ADR_CTRL)) begin
                en      <= wdata[BIT_EN];
                ilace_q <= wdata[BIT_ILACE];
                rep_q   <= wdata[BIT_REP];
            end
            if (addr == ADDR_W'(ADR_ACT))   act_q <= wdata;
            if (addr == ADDR_W'(ADR_BACK))  bp_q  <= wdata;
            if (addr == ADDR_W'(ADR_FRONT)) fp_q  <= wdata;
            if (addr == ADDR_W'(ADR_SYNC))  sw_q  <= wdata;
            if (addr == ADDR_W'(ADR_POL))   pol_q <= wdata[1:0];
        end
    end

    always_comb begin
        stage.interlace = ilace_q;
        stage.rep2x     = rep_q;
        stage.pol       = pol_q;
        stage.h.act     = act_q[FIELD_W-1:0];
        stage.h.bp      = bp_q[FIELD_W-1:0];
        stage.h.fp      = fp_q[FIELD_W-1:0];
        stage.h.sw      = sw_q[FIELD_W-1:0];
        stage.v.act     = act_q[2*FIELD_W-1:FIELD_W];
        stage.v.bp      = bp_q[2*FIELD_W-1:FIELD_W];
        stage.v.fp      = fp_q[2*FIELD_W-1:FIELD_W];
        stage.v.sw      = sw_q[2*FIELD_W-1:FIELD_W];
    end

    assign load = !en || idle_load || frame_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    shadow <= '0;
        else if (load) shadow <= stage;
    end

    // working set only moves in a load slot
    assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(shadow));
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
    import vtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               step,
    input  axis_cfg_t          cfg,
    output axis_state_e        state,
    output logic [FIELD_W+1:0] pos,
    output logic               at_last,
    output logic [FIELD_W-1:0] idx
);
    localparam int PW = FIELD_W + 2;

    axis_state_e    nxt;
    logic [PW-1:0]  pos_nxt;
    logic [PW-1:0]  sw_e, bp_e, act_e, fp_e, end_act, last;

    assign sw_e    = PW'(cfg.sw);
    assign bp_e    = PW'(cfg.bp);
    assign act_e   = PW'(cfg.act);
    assign fp_e    = PW'(cfg.fp);
    assign end_act = bp_e + act_e + PW'(1);
    assign last    = end_act + fp_e + PW'(1);
    assign at_last = (state == ST_FRONT) && (pos == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pos   <= '0;
        end else if (!run) begin
            state <= ST_IDLE;
            pos   <= '0;
        end else begin
            state <= nxt;
            pos   <= pos_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        pos_nxt = pos;
        unique case (state)
            ST_IDLE: begin
                nxt     = ST_SYNC;
                pos_nxt = '0;
            end
            ST_SYNC: if (step) begin
                pos_nxt = pos + PW'(1);
                if (pos == sw_e) nxt = (sw_e == bp_e) ? ST_ACTIVE : ST_PORCH;
            end
            ST_PORCH: if (step) begin
                pos_nxt = pos + PW'(1);
                if (pos == bp_e) nxt = ST_ACTIVE;
            end
            ST_ACTIVE: if (step) begin
                pos_nxt = pos + PW'(1);
                if (pos == end_act) nxt = ST_FRONT;
            end
            ST_FRONT: if (step) begin
                if (pos == last) begin
                    nxt     = ST_SYNC;
                    pos_nxt = '0;
                end else begin
                    pos_nxt = pos + PW'(1);
                end
            end
            default: begin
                nxt     = ST_IDLE;
                pos_nxt = '0;
            end
        endcase
    end

    assign idx = (state == ST_ACTIVE) ? FIELD_W'(pos - bp_e - PW'(1)) : '0;

    // line / frame wrap (R2 horizontally, R3 vertically)
    assert_wrap_to_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && at_last) |=> (state == ST_SYNC && pos == '0));
    assert_idle_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state == ST_IDLE && pos == '0));
endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               de_o,
    output logic [FIELD_W-1:0] col_o,
    output logic [FIELD_W-1:0] row_o,
    output logic               frame_start_o,
    output logic               field_o
);
    logic               en;
    vtg_cfg_t           cfg;
    axis_state_e        h_state, v_state;
    logic [FIELD_W+1:0] h_pos, v_pos;
    logic               h_last, v_last, frame_end;
    logic [FIELD_W-1:0] h_idx, v_idx;

    assign frame_end = h_last && v_last;

    vtg_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .frame_end(frame_end), .idle_load(h_state == ST_IDLE),
        .en(en), .shadow(cfg)
    );

    vtg_axis h_axis_i (
        .clk(clk), .rst_n(rst_n), .run(en), .step(1'b1), .cfg(cfg.h),
        .state(h_state), .pos(h_pos), .at_last(h_last), .idx(h_idx)
    );

    vtg_axis v_axis_i (
        .clk(clk), .rst_n(rst_n), .run(en), .step(h_last), .cfg(cfg.v),
        .state(v_state), .pos(v_pos), .at_last(v_last), .idx(v_idx)
    );

    assign hsync_o       = (h_state == ST_SYNC) ? cfg.pol[0] : ~cfg.pol[0];
    assign vsync_o       = (v_state == ST_SYNC) ? cfg.pol[1] : ~cfg.pol[1];
    assign de_o          = (h_state == ST_ACTIVE) && (v_state == ST_ACTIVE);
    assign col_o         = cfg.rep2x ? (h_idx >> 1) : h_idx;
    assign row_o         = v_idx;
    assign frame_start_o = (h_state == ST_SYNC) && (v_state == ST_SYNC) &&
                           (h_pos == '0) && (v_pos == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         field_o <= 1'b0;
        else if (!en)       field_o <= 1'b0;
        else if (frame_end) field_o <= cfg.interlace ? ~field_o : 1'b0;
    end

    assert_fs_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> !frame_start_o);
    assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!de_o && !frame_start_o && !field_o));
    assert_de_outside_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (hsync_o == ~cfg.pol[0]));
endmodule

// File: tb/vtg_top_tb_top.sv
module vtg_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        hsync_o, vsync_o, de_o, frame_start_o, field_o;
    logic [15:0] col_o, row_o;

    int checks = 0;
    int errors = 0;
    string phase = "R6";

    // bench model of the programmed registers and the counters
    logic [31:0] st [6];
    logic [31:0] sh [6];
    bit m_idle = 1;
    int m_hp = 0;
    int m_vp = 0;
    bit m_field = 0;

    always #2.5 clk = ~clk;

    vtg_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .col_o(col_o), .row_o(row_o),
        .frame_start_o(frame_start_o), .field_o(field_o)
    );

    function automatic int hf(input logic [31:0] w); return int'(w[15:0]); endfunction
    function automatic int vf(input logic [31:0] w); return int'(w[31:16]); endfunction
    function automatic int htot(); return hf(sh[2]) + hf(sh[1]) + hf(sh[3]) + 3; endfunction
    function automatic int vtot(); return vf(sh[2]) + vf(sh[1]) + vf(sh[3]) + 3; endfunction
    function automatic int stage_frame();
        return (hf(st[2]) + hf(st[1]) + hf(st[3]) + 3) * (vf(st[2]) + vf(st[1]) + vf(st[3]) + 3);
    endfunction
    function automatic logic [31:0] pack(input int v, input int h);
        return {v[15:0], h[15:0]};
    endfunction

    task automatic chk(input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s (%s) got %0d expected %0d", what, phase, got, exp);
        end
    endtask

    task automatic compare();
        int hsw, hbp, hact, vsw, vbp, vact;
        bit hs_a, vs_a, h_in, v_in;
        int ecol, erow;
        hsw = hf(sh[4]); hbp = hf(sh[2]); hact = hf(sh[1]);
        vsw = vf(sh[4]); vbp = vf(sh[2]); vact = vf(sh[1]);
        hs_a = !m_idle && (m_hp <= hsw);
        vs_a = !m_idle && (m_vp <= vsw);
        h_in = !m_idle && (m_hp >= hbp + 1) && (m_hp <= hbp + hact + 1);
        v_in = !m_idle && (m_vp >= vbp + 1) && (m_vp <= vbp + vact + 1);
        ecol = h_in ? ((m_hp - hbp - 1) >> (sh[0][0] ? 1 : 0)) : 0;
        erow = v_in ? (m_vp - vbp - 1) : 0;
        chk(int'(hsync_o), int'(hs_a ? sh[5][0] : !sh[5][0]), "hsync R2 R5");
        chk(int'(vsync_o), int'(vs_a ? sh[5][1] : !sh[5][1]), "vsync R3 R5");
        chk(int'(de_o), int'(h_in && v_in), "de R4");
        chk(int'(col_o), ecol, "col R8");
        chk(int'(row_o), erow, "row R8");
        chk(int'(frame_start_o), int'(!m_idle && m_hp == 0 && m_vp == 0), "frame_start R7");
        chk(int'(field_o), int'(m_field), "field R10");
    endtask

    task automatic model_step();
        bit en, fend;
        en = st[0][31];
        fend = !m_idle && (m_hp == htot() - 1) && (m_vp == vtot() - 1);
        if (!en || m_idle || fend) begin
            for (int i = 0; i < 6; i++) sh[i] = st[i];
        end
        if (!en) begin
            m_idle = 1; m_hp = 0; m_vp = 0; m_field = 0;
        end else if (m_idle) begin
            m_idle = 0; m_hp = 0; m_vp = 0;
        end else if (fend) begin
            m_hp = 0; m_vp = 0;
            m_field = sh_ilace_prev ? !m_field : 1'b0;
        end else if (m_hp == htot() - 1) begin
            m_hp = 0; m_vp++;
        end else begin
            m_hp++;
        end
    endtask

    // interlace value used at a boundary is the one in force during the ending frame
    bit sh_ilace_prev;

    // called at a falling edge: check, drive, advance model, pass the rising edge
    task automatic cycle(input bit we, input int a, input logic [31:0] d);
        compare();
        cfg_we = we; cfg_addr = a[2:0]; cfg_wdata = d;
        sh_ilace_prev = sh[0][4];
        model_step();
        if (we && a <= 5) st[a] = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle(0, 0, '0);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        cycle(1, a, d);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (%s) got 1 expected 0", phase);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(20240611);
        for (int i = 0; i < 6; i++) begin st[i] = '0; sh[i] = '0; end
        sh_ilace_prev = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // reset state: disabled, active-low syncs idle high (R6)
        phase = "R6 reset";
        run(4);

        // R1: program a frame while stopped, plus ignored addresses 6 and 7
        phase = "R1 program";
        wr(1, pack(3, 7));
        wr(2, pack(2, 3));
        wr(3, pack(1, 2));
        wr(4, pack(0, 1));
        wr(5, 32'h0000_0001);
        wr(6, 32'hFFFF_FFFF);
        wr(7, 32'hFFFF_FFFF);
        run(3);
        // R6: enable, frame_start follows two clocks after the storing edge
        phase = "R6 enable";
        wr(0, 32'h8000_0000);
        run(2 * stage_frame() + 5);

        // R9: random reprogramming while running; new values wait for the frame end
        for (int it = 0; it < 14; it++) begin
            int hsw, hbp, hact, hfp, vsw, vbp, vact, vfp;
            bit rep;
            phase = "R9 reload";
            rep  = ($urandom % 2) == 1;
            hsw  = $urandom % 3;
            hbp  = hsw + ($urandom % 3);
            hact = rep ? (2 * ($urandom % 5) + 1) : ($urandom % 10);
            hfp  = $urandom % 3;
            vsw  = $urandom % 2;
            vbp  = vsw + ($urandom % 3);
            vact = $urandom % 6;
            vfp  = $urandom % 3;
            run($urandom % 40);
            wr(4, pack(vsw, hsw));
            wr(2, pack(vbp, hbp));
            wr(1, pack(vact, hact));
            wr(3, pack(vfp, hfp));
            wr(5, 32'($urandom % 4));
            phase = "R10 R8 ctrl";
            wr(0, 32'h8000_0000 | (($urandom % 2) << 4) | 32'(rep));
            run(htot() * vtot() + 2 * stage_frame() + 3);
        end

        // R2 R3 minimum geometry: every field zero, porch of zero length
        phase = "R2 R3 minimum";
        wr(1, 32'h0); wr(2, 32'h0); wr(3, 32'h0); wr(4, 32'h0);
        wr(0, 32'h8000_0010);
        run(htot() * vtot() + 4 * stage_frame() + 3);

        // R6: stop mid-frame, stay quiet, restart
        phase = "R6 disable";
        wr(1, pack(2, 5)); wr(2, pack(2, 2)); wr(4, pack(1, 1));
        run(7);
        wr(0, 32'h0000_0010);
        run(20);
        wr(5, 32'h0000_0002);
        run(2);
        wr(0, 32'h8000_0001);
        run(2 * stage_frame() + 5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule